// File: doc/BRIEF.md
# Packet-to-Local-Bus Transaction Engine

This engine sits behind a packet receiver and turns the payload of packets aimed at the local-bus sub-slot into 32-bit local bus cycles. A packet opens with a one-cycle start strobe that carries a 4-bit command code. Payload bytes follow, one per valid cycle, and a one-cycle end marker closes the packet. Every packet begins with a 32-bit address. A write packet then carries data words. A read packet carries a single byte that gives how many words to fetch.

Each write word goes out as a one-cycle write strobe once all four of its bytes are in. Reads are issued one at a time. The engine waits for the acknowledge of each read before it starts the next one, and each returned word leaves as four bytes on a readback stream. A framing block builds the reply packet from that stream. The plain commands step the address by 4 after every word. The repeat commands keep the address fixed, which suits a FIFO-style register.

Top module: `lbx_engine`

## Requirements
- R1: After reset, `lb_wr`, `lb_rd` and `rb_valid` are low and stay low until a packet with a known command arrives.
- R2: The first four payload bytes after `pkt_start` form the address, most significant byte first. In a write, every later group of four bytes forms a data word, most significant byte first. `lb_wr` is high for exactly the one cycle after the cycle that accepts the word's fourth byte, with `lb_wdata` holding the word and `lb_addr` the target.
- R3: With command 0x0 (write), the target of each word after the first is the previous target plus 4.
- R4: With command 0x2 (write-repeat), every word of the packet targets the packet's address.
- R5: A write word still missing bytes when `pkt_end` arrives is dropped with no strobe. The next packet starts from a clean byte count.
- R6: With command 0x1 or 0x3, the byte after the address is a count N. The engine raises `lb_rd` for one cycle N times. It raises no new `lb_rd` before the previous read is acknowledged and its bytes are sent. N = 0 gives no read.
- R7: An `lb_rack` accepted while a read is pending captures `lb_rdata`. From the next cycle on, `rb_valid` is high for four consecutive cycles, and `rb_byte` carries bits 31:24, 23:16, 15:8 and 7:0 in that order.
- R8: With command 0x1 each read address is the previous one plus 4. With command 0x3 every read uses the packet's address.
- R9: Commands 0x4 to 0xF make no write, no read and no readback. Their payload is consumed up to `pkt_end`.
- R10: Payload bytes that arrive outside a packet, or after the count byte of a read packet, have no effect on bus cycles, addresses or readback.
- R11: `lb_wr` and `lb_rd` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_start | input | 1 | One-cycle packet opening strobe, carries no payload byte |
| pkt_cmd | input | 4 | Command code, valid with `pkt_start` |
| pay_valid | input | 1 | Payload byte present this cycle |
| pay_byte | input | 8 | Payload byte |
| pkt_end | input | 1 | Packet closing marker; a byte in the same cycle is taken first |
| lb_addr | output | 32 | Local bus address |
| lb_wdata | output | 32 | Local bus write data |
| lb_wr | output | 1 | One-cycle write strobe |
| lb_rd | output | 1 | One-cycle read request |
| lb_rdata | input | 32 | Local bus read data, valid with `lb_rack` |
| lb_rack | input | 1 | Read acknowledge, at least one cycle after `lb_rd` |
| rb_valid | output | 1 | Readback byte valid |
| rb_byte | output | 8 | Readback byte |

## Verification
The write tests use a multi-word packet with a stepping address and a repeat packet with a held address, which separates the two address modes. A packet that ends on a partial word shows whether leftover bytes leak into the next packet's address. The read tests vary the count (three words, two repeated words, zero) and add stray bytes after the count, and the responder returns a serial number in every word, so a reordered, skipped or doubled read shows up in the readback bytes. A packet with an unknown command and bytes sent with no packet open must leave the bus silent, and a normal write afterwards must still land correctly.

// File: rtl/lbx_pkg.sv
package lbx_pkg;

  localparam int CMD_W = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WDATA,
    ST_RLEN,
    ST_RREQ,
    ST_RWAIT,
    ST_RSEND,
    ST_DRAIN
  } lbx_state_t;

  // codes 0..3 are served; bit 0 selects read, bit 1 selects repeat
  function automatic logic cmd_known(input logic [CMD_W-1:0] c);
    return c[CMD_W-1:2] == '0;
  endfunction

  function automatic logic cmd_is_read(input logic [CMD_W-1:0] c);
    return c[0];
  endfunction

  function automatic logic cmd_is_rep(input logic [CMD_W-1:0] c);
    return c[1];
  endfunction

endpackage

// File: rtl/lbx_word_asm.sv
module lbx_word_asm #(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  output logic              word_done,
  output logic [DATA_W-1:0] word
);
  localparam int BPW = DATA_W / BYTE_W;
  localparam int CW  = $clog2(BPW);

  logic [DATA_W-1:0] sh_q;
  logic [CW-1:0]     cnt_q;

  // big-endian gather: newest byte lands in the low lane
  function automatic logic [DATA_W-1:0] push_byte(input logic [DATA_W-1:0] s,
                                                  input logic [BYTE_W-1:0] b);
    return {s[DATA_W-BYTE_W-1:0], b};
  endfunction

  assign word_done = in_valid && (cnt_q == CW'(BPW - 1));
  assign word      = push_byte(sh_q, in_byte);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (clr) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (in_valid) begin
      sh_q  <= word;
      cnt_q <= word_done ? '0 : cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/lbx_addr_gen.sv
module lbx_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int STEP   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              step,
  input  logic              hold,
  output logic [ADDR_W-1:0] addr
);
  function automatic logic [ADDR_W-1:0] next_addr(input logic [ADDR_W-1:0] a,
                                                  input logic h);
    return h ? a : a + ADDR_W'(STEP);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    addr <= '0;
    else if (load) addr <= load_val;
    else if (step) addr <= next_addr(addr, hold);
  end

  assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !hold && !load) |=> addr == $past(addr) + ADDR_W'(STEP));

  assert_addr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && hold && !load) |=> $stable(addr));

endmodule

// File: rtl/lbx_rd_ser.sv
module lbx_rd_ser #(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  output logic              busy,
  output logic              last,
  output logic [BYTE_W-1:0] out_byte
);
  localparam int BPW = DATA_W / BYTE_W;
  localparam int CW  = $clog2(BPW);

  logic [DATA_W-1:0] sh_q;
  logic [CW-1:0]     cnt_q;

  assign out_byte = sh_q[DATA_W-1 -: BYTE_W];
  assign last     = busy && (cnt_q == CW'(BPW - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
      busy  <= 1'b0;
    end else if (load) begin
      sh_q  <= din;
      cnt_q <= '0;
      busy  <= 1'b1;
    end else if (busy) begin
      sh_q  <= sh_q << BYTE_W;
      cnt_q <= cnt_q + 1'b1;
      if (last) busy <= 1'b0;
    end
  end

  assert_ser_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> busy && out_byte == $past(din[DATA_W-1 -: BYTE_W]));

  assert_ser_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (last && !load) |=> !busy);

endmodule

// File: rtl/lbx_engine.sv
module lbx_engine #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  parameter int LEN_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      pkt_start,
  input  logic [lbx_pkg::CMD_W-1:0] pkt_cmd,
  input  logic                      pay_valid,
  input  logic [BYTE_W-1:0]         pay_byte,
  input  logic                      pkt_end,
  output logic [ADDR_W-1:0]         lb_addr,
  output logic [DATA_W-1:0]         lb_wdata,
  output logic                      lb_wr,
  output logic                      lb_rd,
  input  logic [DATA_W-1:0]         lb_rdata,
  input  logic                      lb_rack,
  output logic                      rb_valid,
  output logic [BYTE_W-1:0]         rb_byte
);
  import lbx_pkg::*;

  localparam int STEP = DATA_W / BYTE_W;

  lbx_state_t        state_q, state_n;
  logic              rep_q, rd_q, bad_q, end_seen_q;
  logic [LEN_W-1:0]  remain_q;
  logic [DATA_W-1:0] wdata_q;
  logic              wr_q;

  // named internal events
  logic              asm_clr, asm_in, asm_done;
  logic [DATA_W-1:0] asm_word;
  logic              addr_load, word_issue, addr_step;
  logic              ser_load, ser_busy, ser_last;
  logic [BYTE_W-1:0] ser_byte;
  logic              len_take, reads_done, closed_now;
  lbx_state_t        after_reads;

  assign asm_clr    = (state_q == ST_IDLE);
  assign asm_in     = pay_valid && (state_q == ST_ADDR || state_q == ST_WDATA);
  assign addr_load  = asm_done && (state_q == ST_ADDR);
  assign word_issue = asm_done && (state_q == ST_WDATA);
  assign len_take   = pay_valid && (state_q == ST_RLEN);
  assign ser_load   = lb_rack && (state_q == ST_RWAIT);
  assign reads_done = ser_last && (state_q == ST_RSEND) && (remain_q == LEN_W'(1));
  assign addr_step  = wr_q || (ser_last && state_q == ST_RSEND);
  assign closed_now = end_seen_q || pkt_end;
  assign after_reads = closed_now ? ST_IDLE : ST_DRAIN;

  lbx_word_asm #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_asm (
    .clk(clk), .rst_n(rst_n), .clr(asm_clr), .in_valid(asm_in),
    .in_byte(pay_byte), .word_done(asm_done), .word(asm_word)
  );

  lbx_addr_gen #(.ADDR_W(ADDR_W), .STEP(STEP)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(addr_load), .load_val(ADDR_W'(asm_word)),
    .step(addr_step), .hold(rep_q), .addr(lb_addr)
  );

  lbx_rd_ser #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_ser (
    .clk(clk), .rst_n(rst_n), .load(ser_load), .din(lb_rdata),
    .busy(ser_busy), .last(ser_last), .out_byte(ser_byte)
  );

  always_comb begin
    state_n = state_q;
    unique case (state_q)
      ST_IDLE:  if (pkt_start) state_n = cmd_known(pkt_cmd) ? ST_ADDR : ST_DRAIN;
      ST_ADDR: begin
        if (pkt_end)        state_n = ST_IDLE;
        else if (addr_load) state_n = rd_q ? ST_RLEN : ST_WDATA;
      end
      ST_WDATA: if (pkt_end) state_n = ST_IDLE;
      ST_RLEN: begin
        if (len_take) begin
          if (pay_byte == '0) state_n = pkt_end ? ST_IDLE : ST_DRAIN;
          else                state_n = ST_RREQ;
        end else if (pkt_end) begin
          state_n = ST_IDLE;
        end
      end
      ST_RREQ:  state_n = ST_RWAIT;
      ST_RWAIT: if (lb_rack) state_n = ST_RSEND;
      ST_RSEND: begin
        if (reads_done)    state_n = after_reads;
        else if (ser_last) state_n = ST_RREQ;
      end
      ST_DRAIN: if (pkt_end) state_n = ST_IDLE;
      default:  state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      rep_q      <= 1'b0;
      rd_q       <= 1'b0;
      bad_q      <= 1'b0;
      end_seen_q <= 1'b0;
      remain_q   <= '0;
      wr_q       <= 1'b0;
      wdata_q    <= '0;
    end else begin
      state_q <= state_n;
      wr_q    <= word_issue;
      if (word_issue) wdata_q <= asm_word;
      if (state_q == ST_IDLE) begin
        end_seen_q <= 1'b0;
        if (pkt_start) begin
          rep_q <= cmd_is_rep(pkt_cmd);
          rd_q  <= cmd_is_read(pkt_cmd);
          bad_q <= !cmd_known(pkt_cmd);
        end else begin
          bad_q <= 1'b0;
        end
      end else if (pkt_end) begin
        end_seen_q <= 1'b1;
      end
      if (len_take)                            remain_q <= LEN_W'(pay_byte);
      else if (ser_last && state_q == ST_RSEND) remain_q <= remain_q - 1'b1;
    end
  end

  assign lb_wr    = wr_q;
  assign lb_wdata = wdata_q;
  assign lb_rd    = (state_q == ST_RREQ);
  assign rb_valid = ser_busy;
  assign rb_byte  = ser_byte;

  assert_strobe_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
    word_issue |=> lb_wr && lb_wdata == $past(asm_word));

  assert_strobe_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (lb_wr && !word_issue) |=> !lb_wr);

  assert_partial_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WDATA && pkt_end && !asm_done) |=> !lb_wr);

  assert_rd_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lb_rd |=> !lb_rd);

  assert_rd_no_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lb_rd |-> !ser_busy);

  assert_ignored_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bad_q |-> !lb_wr && !lb_rd && !rb_valid);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> !lb_rd && !rb_valid);

  assert_wr_rd_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(lb_wr && lb_rd));

endmodule

// File: tb/lbx_engine_test.sv
module lbx_engine_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pkt_start = 1'b0;
  logic [3:0]  pkt_cmd = '0;
  logic        pay_valid = 1'b0;
  logic [7:0]  pay_byte = '0;
  logic        pkt_end = 1'b0;
  logic [31:0] lb_addr, lb_wdata, lb_rdata;
  logic        lb_wr, lb_rd, lb_rack;
  logic        rb_valid;
  logic [7:0]  rb_byte;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  lbx_engine uut (
    .clk(clk), .rst_n(rst_n), .pkt_start(pkt_start), .pkt_cmd(pkt_cmd),
    .pay_valid(pay_valid), .pay_byte(pay_byte), .pkt_end(pkt_end),
    .lb_addr(lb_addr), .lb_wdata(lb_wdata), .lb_wr(lb_wr), .lb_rd(lb_rd),
    .lb_rdata(lb_rdata), .lb_rack(lb_rack), .rb_valid(rb_valid), .rb_byte(rb_byte)
  );

  // event logs
  logic [31:0] wr_addr_log [64];
  logic [31:0] wr_data_log [64];
  logic [31:0] rd_addr_log [64];
  logic [7:0]  rb_log      [256];
  int wr_n = 0, rd_n = 0, rb_n = 0;
  int serial = 0;
  int overlap_seen = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // monitor, samples away from the active edge
  initial begin
    lb_rack  = 1'b0;
    lb_rdata = '0;
    forever begin
      @(negedge clk);
      if (lb_wr && lb_rd) overlap_seen++;
      if (lb_wr && wr_n < 64) begin
        wr_addr_log[wr_n] = lb_addr; wr_data_log[wr_n] = lb_wdata; wr_n++;
      end
      if (lb_rd && rd_n < 64) begin
        rd_addr_log[rd_n] = lb_addr; rd_n++;
      end
      if (rb_valid && rb_n < 256) begin
        rb_log[rb_n] = rb_byte; rb_n++;
      end
    end
  end

  // local bus read responder: ack one cycle after the request
  function automatic logic [31:0] model_word(input logic [31:0] a, input int s);
    return {a[23:0], 8'(s)};
  endfunction

  initial begin
    forever begin
      @(negedge clk);
      if (lb_rd) begin
        logic [31:0] v;
        v = model_word(lb_addr, serial);
        serial++;
        @(negedge clk);
        chk(!lb_rd, "R6", "request while read pending", 32'(lb_rd), 0);
        lb_rack = 1'b1; lb_rdata = v;
        @(negedge clk);
        lb_rack = 1'b0;
        chk(rb_valid && rb_byte == v[31:24], "R7", "first readback byte after ack",
            {23'd0, rb_valid, rb_byte}, {23'd1, 1'b1, v[31:24]} & 32'h1ff | 32'h100);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic clear_logs();
    wr_n = 0; rd_n = 0; rb_n = 0; serial = 0;
  endtask

  task automatic start(input logic [3:0] c);
    pkt_start = 1'b1; pkt_cmd = c;
    @(negedge clk);
    pkt_start = 1'b0;
  endtask

  task automatic put(input logic [7:0] b);
    pay_valid = 1'b1; pay_byte = b;
    @(negedge clk);
    pay_valid = 1'b0;
  endtask

  task automatic put32(input logic [31:0] w);
    for (int i = 3; i >= 0; i--) put(w[i*8 +: 8]);
  endtask

  task automatic finish_pkt();
    pkt_end = 1'b1;
    @(negedge clk);
    pkt_end = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(!lb_wr && !lb_rd && !rb_valid, "R1", "outputs after reset",
        {29'd0, lb_wr, lb_rd, rb_valid}, 0);
    idle(4);
    chk(wr_n == 0 && rd_n == 0 && rb_n == 0, "R1", "quiet before any packet",
        32'(wr_n + rd_n + rb_n), 0);
  endtask

  task automatic t_write_incr();
    logic [31:0] d [3] = '{32'hDEADBEEF, 32'h01234567, 32'hA5C3_0F1E};
    clear_logs();
    start(4'h0);
    put32(32'h1000_0010);
    for (int i = 0; i < 3; i++) begin
      put32(d[i]);
      chk(lb_wr && lb_wdata == d[i], "R2", "strobe the cycle after fourth byte",
          lb_wdata, d[i]);
    end
    finish_pkt();
    idle(3);
    chk(wr_n == 3, "R2", "write count", 32'(wr_n), 3);
    for (int i = 0; i < 3; i++) begin
      chk(wr_addr_log[i] == 32'h1000_0010 + 32'(4*i), "R3", "incrementing target",
          wr_addr_log[i], 32'h1000_0010 + 32'(4*i));
      chk(wr_data_log[i] == d[i], "R2", "data MSB first", wr_data_log[i], d[i]);
    end
  endtask

  task automatic t_write_repeat();
    clear_logs();
    start(4'h2);
    put32(32'h2000_0040);
    put32(32'h1111_2222);
    put32(32'h3333_4444);
    finish_pkt();
    idle(3);
    chk(wr_n == 2, "R4", "repeat write count", 32'(wr_n), 2);
    for (int i = 0; i < 2; i++)
      chk(wr_addr_log[i] == 32'h2000_0040, "R4", "held target", wr_addr_log[i], 32'h2000_0040);
    chk(wr_data_log[1] == 32'h3333_4444, "R4", "second repeat data", wr_data_log[1], 32'h3333_4444);
  endtask

  task automatic t_partial();
    clear_logs();
    start(4'h0);
    put32(32'h0000_0100);
    put32(32'hCAFEF00D);
    put(8'h77); put(8'h88);
    finish_pkt();
    idle(3);
    chk(wr_n == 1, "R5", "trailing partial word dropped", 32'(wr_n), 1);
    start(4'h0);
    put32(32'h0000_0200);
    put32(32'h5555_AAAA);
    finish_pkt();
    idle(3);
    chk(wr_n == 2 && wr_addr_log[1] == 32'h0000_0200, "R5", "clean count in next packet",
        wr_addr_log[1], 32'h0000_0200);
  endtask

  task automatic t_read(input logic [3:0] c, input logic [31:0] a, input int n,
                        input int extra, input string req_a);
    clear_logs();
    start(c);
    put32(a);
    put(8'(n));
    for (int i = 0; i < extra; i++) put(8'hE0 + 8'(i));
    finish_pkt();
    idle(n * 8 + 12);
    chk(rd_n == n, "R6", "read request count", 32'(rd_n), 32'(n));
    chk(rb_n == 4 * n, "R7", "readback byte count", 32'(rb_n), 32'(4 * n));
    for (int i = 0; i < n && i < rd_n; i++) begin
      logic [31:0] ea, ev;
      ea = (c == 4'h3) ? a : a + 32'(4 * i);
      ev = model_word(ea, i);
      chk(rd_addr_log[i] == ea, req_a, "read address", rd_addr_log[i], ea);
      for (int k = 0; k < 4; k++)
        if (4 * i + k < rb_n)
          chk(rb_log[4*i+k] == ev[31-8*k -: 8], "R7", "readback byte order",
              32'(rb_log[4*i+k]), 32'(ev[31-8*k -: 8]));
    end
  endtask

  task automatic t_ignored();
    clear_logs();
    start(4'h5);
    put32(32'h0000_0300);
    put32(32'h1234_5678);
    finish_pkt();
    start(4'hF);
    put32(32'h0000_0400);
    put(8'h02);
    finish_pkt();
    idle(20);
    chk(wr_n == 0 && rd_n == 0 && rb_n == 0, "R9", "unknown commands silent",
        32'(wr_n + rd_n + rb_n), 0);
  endtask

  task automatic t_stray();
    clear_logs();
    for (int i = 0; i < 9; i++) put(8'h10 + 8'(i));
    finish_pkt();
    idle(5);
    chk(wr_n == 0 && rd_n == 0 && rb_n == 0, "R10", "bytes outside packet ignored",
        32'(wr_n + rd_n + rb_n), 0);
    start(4'h0);
    put32(32'h0000_0500);
    put32(32'h0BAD_F00D);
    finish_pkt();
    idle(3);
    chk(wr_n == 1 && wr_addr_log[0] == 32'h0000_0500, "R10", "write after stray bytes",
        wr_addr_log[0], 32'h0000_0500);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_incr();
    t_write_repeat();
    t_partial();
    t_read(4'h1, 32'h3000_0100, 3, 0, "R8");
    t_read(4'h3, 32'h4000_0000, 2, 0, "R8");
    t_read(4'h1, 32'h5000_0000, 0, 0, "R6");
    t_read(4'h1, 32'h6000_0020, 2, 4, "R10");
    t_ignored();
    t_stray();
    chk(overlap_seen == 0, "R11", "write and read strobes overlap", 32'(overlap_seen), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule